// File: doc/BRIEF.md
# Cartridge Bank Decoder with Ping-Pong SPI Buffers

This block sits between a console's banked memory bus and the storage on a cartridge. Every console access arrives with a window flag (ROM window or RAM window), the bank number for that window and a 16-bit offset. The block turns it into a request for one physical target: one of two external PSRAM chips, external SRAM, a boot ROM, an on-chip buffer, or nothing at all (open bus). The external memories and the boot ROM contents are outside the block. They are reached through simple request ports that answer within the same cycle.

The block holds three on-chip 512-byte stores. One is a general scratch buffer that the console can read and write. The other two are double-buffered halves for SPI traffic. The console sees one half of the receive pair and one half of the transmit pair, and the SPI engine uses the other halves. A swap pulse exchanges the halves. A swap requested during an SPI transfer waits until the transfer ends.

A self-flash flag redirects RAM-window accesses onto the ROM bank map as byte accesses. This is the only way the PSRAM chips can be written.

Top module: `cart_bank_decoder`

## Requirements
- R1: ROM bank b with b < 128 reaches PSRAM chip 0 (`psramSel`=0), and 128 <= b < 256 reaches chip 1 (`psramSel`=1). In both cases `psramAddr` = {b[6:0], offset}, `psramWord` follows `busWord`, and a read returns `psramRData`.
- R2: ROM banks 256–499 and 501–509, and RAM banks 8–13, raise no external request. A read from them returns 0xFFFF for a word access and 0x00FF for a byte access.
- R3: ROM banks 511 and 500 both read the boot ROM with `bootAddr` = offset[15:1]. The result is always the full 16-bit `bootRData`, even for a byte access.
- R4: ROM bank 510 returns the 16-bit word at index offset[8:1] of the console-visible receive half, so it repeats every 512 bytes. Writes to this bank change nothing.
- R5: RAM banks 0–7 reach SRAM at `sramAddr` = {bank[2:0], offset} with byte data on `sramWData`/`sramRData`. RAM-window accesses are always byte accesses whatever `busWord` says, and byte reads return {0x00, byte}.
- R6: RAM bank 14 is a 512-byte read/write scratch buffer indexed by offset[8:0], so it is mirrored across the bank.
- R7: RAM bank 15 writes byte offset[8:0] of the console-visible transmit half. Reads from it return the open-bus value 0x00FF.
- R8: Every ROM-window write is ignored: no PSRAM or SRAM write strobe, and no buffer changes.
- R9: With `selfFlash`=1, RAM-window accesses are decoded through the ROM map using `romBank`, always as byte accesses. PSRAM writes are allowed on this path (`psramWe`=1, `psramWord`=0).
- R10: A `swapReq` pulse with `spiActive` low exchanges both pairs at that clock edge. Data the SPI side wrote into the hidden receive half then becomes readable in bank 510, and transmit data the console wrote becomes readable on `spiTxData` one cycle after `spiTxAddr` is applied.
- R11: A `swapReq` while `spiActive` is high is held, with at most one swap pending. It takes effect at the first edge where `spiActive` is low.
- R12: After reset `rdValid` is 0 and the console sees half 0. `rdValid` pulses exactly one cycle after each read request and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Console access strobe, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = 16-bit access (ROM window only) |
| isRom | input | 1 | 1 = ROM window, 0 = RAM window |
| romBank | input | 9 | ROM window bank number |
| ramBank | input | 4 | RAM window bank number |
| offset | input | 16 | Byte offset inside the bank |
| busWData | input | 16 | Write data (byte writes use bits 7:0) |
| selfFlash | input | 1 | Maps the RAM window onto the ROM bank map |
| rdValid | output | 1 | Read result valid |
| rdData | output | 16 | Read result |
| swapReq | input | 1 | Pulse that requests a buffer half exchange |
| spiActive | input | 1 | An SPI transfer is in progress |
| spiRxWe | input | 1 | SPI side writes the hidden receive half |
| spiRxAddr | input | 8 | Word index for the SPI receive write |
| spiRxData | input | 16 | SPI receive write data |
| spiTxAddr | input | 9 | Byte index read from the hidden transmit half |
| spiTxData | output | 8 | Hidden transmit byte, one cycle after the address |
| psramReq | output | 1 | PSRAM access request |
| psramWe | output | 1 | PSRAM write |
| psramSel | output | 1 | PSRAM chip select: 0 = first, 1 = second |
| psramWord | output | 1 | PSRAM 16-bit access |
| psramAddr | output | 23 | PSRAM byte address within the chip |
| psramWData | output | 16 | PSRAM write data |
| psramRData | input | 16 | PSRAM read data, same cycle (byte in bits 7:0) |
| sramReq | output | 1 | SRAM access request |
| sramWe | output | 1 | SRAM write |
| sramAddr | output | 19 | SRAM byte address |
| sramWData | output | 8 | SRAM write byte |
| sramRData | input | 8 | SRAM read byte, same cycle |
| bootReq | output | 1 | Boot ROM read request |
| bootAddr | output | 15 | Boot ROM word address |
| bootRData | input | 16 | Boot ROM word, same cycle |

## Verification
The bench builds the block with its default parameters: 128 banks per PSRAM chip, the second chip present, and 512-byte buffers. With these values the chip-1 range, the gaps around the boot mirror at bank 500, and the 512-byte mirror points of the receive and scratch buffers can all be reached with a few accesses at offsets such as 0x0205, 0x4220 and 0xFE05. Because the second chip is present, banks 128–255 decode to PSRAM rather than open bus. The run also takes the swap flop through a free swap and a held swap, so both pairs are seen from both sides.

// File: rtl/cbd_pkg.sv
`timescale 1ns/1ps
package cbd_pkg;

  typedef enum logic [2:0] {
    TGT_OPEN  = 3'd0,
    TGT_PSRAM = 3'd1,
    TGT_BOOT  = 3'd2,
    TGT_RX    = 3'd3,
    TGT_SRAM  = 3'd4,
    TGT_IPC   = 3'd5,
    TGT_TX    = 3'd6
  } tgt_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic rd;       // read accepted this cycle
    logic wr;       // write accepted (target writable)
    tgt_e tgt;      // resolved target
    logic chipHi;   // second PSRAM chip
    logic wordAcc;  // 16-bit access
    logic bufSel;   // console-visible half
  } strobe_t;

endpackage

// File: rtl/cbd_ctrl.sv
`timescale 1ns/1ps
module cbd_ctrl
  import cbd_pkg::*;
#(
  parameter int ROM_BANK_W  = 9,
  parameter int RAM_BANK_W  = 4,
  parameter int PSRAM_BANKS = 128,
  parameter bit HAS_PSRAM1  = 1'b1,
  parameter int SRAM_BANKS  = 8,
  parameter int BOOT_BANK   = 511,
  parameter int BOOT_MIRROR = 500,
  parameter int RX_BANK     = 510,
  parameter int IPC_BANK    = 14,
  parameter int TX_BANK     = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busReq,
  input  logic                  busWe,
  input  logic                  busWord,
  input  logic                  isRom,
  input  logic [ROM_BANK_W-1:0] romBank,
  input  logic [RAM_BANK_W-1:0] ramBank,
  input  logic                  selfFlash,
  input  logic                  swapReq,
  input  logic                  spiActive,
  output strobe_t               stb
);

  localparam logic [ROM_BANK_W-1:0] PS0_END = ROM_BANK_W'(PSRAM_BANKS);
  localparam logic [ROM_BANK_W-1:0] PS1_END = ROM_BANK_W'(2 * PSRAM_BANKS);
  localparam logic [ROM_BANK_W-1:0] BOOT_B  = ROM_BANK_W'(BOOT_BANK);
  localparam logic [ROM_BANK_W-1:0] MIRR_B  = ROM_BANK_W'(BOOT_MIRROR);
  localparam logic [ROM_BANK_W-1:0] RX_B    = ROM_BANK_W'(RX_BANK);
  localparam logic [RAM_BANK_W-1:0] SRAM_END = RAM_BANK_W'(SRAM_BANKS);
  localparam logic [RAM_BANK_W-1:0] IPC_B   = RAM_BANK_W'(IPC_BANK);
  localparam logic [RAM_BANK_W-1:0] TX_B    = RAM_BANK_W'(TX_BANK);

  logic romPath;
  logic flashPath;
  tgt_e romTgt;
  logic romHi;
  tgt_e ramTgt;
  tgt_e rawTgt;
  logic writable;
  logic sel;
  logic pending;

  assign romPath   = isRom || selfFlash;
  assign flashPath = !isRom && selfFlash;

  // ROM bank map
  always_comb begin
    romHi  = 1'b0;
    romTgt = TGT_OPEN;
    if (romBank < PS0_END) begin
      romTgt = TGT_PSRAM;
    end else if (HAS_PSRAM1 && (romBank < PS1_END)) begin
      romTgt = TGT_PSRAM;
      romHi  = 1'b1;
    end else if ((romBank == BOOT_B) || (romBank == MIRR_B)) begin
      romTgt = TGT_BOOT;
    end else if (romBank == RX_B) begin
      romTgt = TGT_RX;
    end
  end

  // RAM bank map
  always_comb begin
    ramTgt = TGT_OPEN;
    if (ramBank < SRAM_END)    ramTgt = TGT_SRAM;
    else if (ramBank == IPC_B) ramTgt = TGT_IPC;
    else if (ramBank == TX_B)  ramTgt = TGT_TX;
  end

  assign rawTgt = romPath ? romTgt : ramTgt;

  // direction rules: ROM map writable only on the self-flash path
  always_comb begin
    writable = 1'b0;
    if (romPath) writable = flashPath && (rawTgt == TGT_PSRAM);
    else         writable = (rawTgt == TGT_SRAM) || (rawTgt == TGT_IPC) || (rawTgt == TGT_TX);
  end

  always_comb begin
    stb.rd      = busReq && !busWe;
    stb.wr      = busReq && busWe && writable;
    stb.chipHi  = romPath && romHi;
    stb.wordAcc = isRom && busWord;
    stb.bufSel  = sel;
    stb.tgt     = rawTgt;
    if (busWe && !writable)            stb.tgt = TGT_OPEN;
    if (!busWe && rawTgt == TGT_TX)    stb.tgt = TGT_OPEN;
  end

  // shared half-select flop with deferred swap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sel     <= 1'b0;
      pending <= 1'b0;
    end else if (spiActive) begin
      if (swapReq) pending <= 1'b1;
    end else if (swapReq || pending) begin
      sel     <= ~sel;
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/cbd_datapath.sv
`timescale 1ns/1ps
module cbd_datapath
  import cbd_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int BUF_BYTES = 512,
  parameter int PS_BW     = 7,
  parameter int SR_BW     = 3,
  localparam int BAW       = $clog2(BUF_BYTES),
  localparam int WAW       = BAW - 1,
  localparam int BUF_WORDS = BUF_BYTES / 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [PS_BW-1:0]        psBank,
  input  logic [SR_BW-1:0]        srBank,
  input  logic [OFF_W-1:0]        offset,
  input  logic [15:0]             busWData,
  output logic                    rdValid,
  output logic [15:0]             rdData,
  input  logic                    spiRxWe,
  input  logic [WAW-1:0]          spiRxAddr,
  input  logic [15:0]             spiRxData,
  input  logic [BAW-1:0]          spiTxAddr,
  output logic [7:0]              spiTxData,
  output logic                    psramReq,
  output logic                    psramWe,
  output logic                    psramSel,
  output logic                    psramWord,
  output logic [PS_BW+OFF_W-1:0]  psramAddr,
  output logic [15:0]             psramWData,
  input  logic [15:0]             psramRData,
  output logic                    sramReq,
  output logic                    sramWe,
  output logic [SR_BW+OFF_W-1:0]  sramAddr,
  output logic [7:0]              sramWData,
  input  logic [7:0]              sramRData,
  output logic                    bootReq,
  output logic [OFF_W-2:0]        bootAddr,
  input  logic [15:0]             bootRData
);

  logic [BAW-1:0] byteOff;
  logic [WAW-1:0] wordOff;
  logic           acc;
  logic [15:0]    extMux;

  assign byteOff = offset[BAW-1:0];
  assign wordOff = offset[BAW-1:1];
  assign acc     = stb.rd || stb.wr;

  // external ports
  assign psramReq   = acc && (stb.tgt == TGT_PSRAM);
  assign psramWe    = stb.wr && (stb.tgt == TGT_PSRAM);
  assign psramSel   = stb.chipHi;
  assign psramWord  = stb.wordAcc;
  assign psramAddr  = {psBank, offset};
  assign psramWData = busWData;
  assign sramReq    = acc && (stb.tgt == TGT_SRAM);
  assign sramWe     = stb.wr && (stb.tgt == TGT_SRAM);
  assign sramAddr   = {srBank, offset};
  assign sramWData  = busWData[7:0];
  assign bootReq    = stb.rd && (stb.tgt == TGT_BOOT);
  assign bootAddr   = offset[OFF_W-1:1];

  always_comb begin
    case (stb.tgt)
      TGT_PSRAM: extMux = psramRData;
      TGT_SRAM:  extMux = {8'h00, sramRData};
      default:   extMux = bootRData;
    endcase
  end

  // ping-pong halves
  logic [15:0] rxRdAll [2];
  logic [7:0]  txRdAll [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [15:0] rxMem [BUF_WORDS];
    logic [7:0]  txMem [BUF_BYTES];
    logic [15:0] rxQ;
    logic [7:0]  txQ;
    always_ff @(posedge clk) begin
      if (spiRxWe && (stb.bufSel != 1'(h)))
        rxMem[spiRxAddr] <= spiRxData;
      if (stb.wr && (stb.tgt == TGT_TX) && (stb.bufSel == 1'(h)))
        txMem[byteOff] <= busWData[7:0];
      rxQ <= rxMem[wordOff];
      txQ <= txMem[spiTxAddr];
    end
    assign rxRdAll[h] = rxQ;
    assign txRdAll[h] = txQ;
  end

  // scratch buffer
  logic [7:0] ipcMem [BUF_BYTES];
  logic [7:0] ipcQ;
  always_ff @(posedge clk) begin
    if (stb.wr && (stb.tgt == TGT_IPC)) ipcMem[byteOff] <= busWData[7:0];
    ipcQ <= ipcMem[byteOff];
  end

  // read return stage
  tgt_e        tgtQ;
  logic        wordQ;
  logic        selQ;
  logic        spiSelQ;
  logic [15:0] extQ;

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= stb.rd;
  end

  always_ff @(posedge clk) begin
    tgtQ    <= stb.tgt;
    wordQ   <= stb.wordAcc;
    selQ    <= stb.bufSel;
    spiSelQ <= ~stb.bufSel;
    extQ    <= extMux;
  end

  always_comb begin
    case (tgtQ)
      TGT_PSRAM: rdData = wordQ ? extQ : {8'h00, extQ[7:0]};
      TGT_SRAM:  rdData = {8'h00, extQ[7:0]};
      TGT_BOOT:  rdData = extQ;
      TGT_RX:    rdData = rxRdAll[selQ];
      TGT_IPC:   rdData = {8'h00, ipcQ};
      default:   rdData = wordQ ? 16'hFFFF : 16'h00FF;
    endcase
  end

  assign spiTxData = txRdAll[spiSelQ];

endmodule

// File: rtl/cart_bank_decoder.sv
`timescale 1ns/1ps
module cart_bank_decoder
  import cbd_pkg::*;
#(
  parameter int ROM_BANK_W  = 9,
  parameter int RAM_BANK_W  = 4,
  parameter int OFF_W       = 16,
  parameter int PSRAM_BANKS = 128,
  parameter bit HAS_PSRAM1  = 1'b1,
  parameter int SRAM_BANKS  = 8,
  parameter int BUF_BYTES   = 512,
  parameter int BOOT_BANK   = 511,
  parameter int BOOT_MIRROR = 500,
  parameter int RX_BANK     = 510,
  parameter int IPC_BANK    = 14,
  parameter int TX_BANK     = 15,
  localparam int PS_BW = $clog2(PSRAM_BANKS),
  localparam int SR_BW = $clog2(SRAM_BANKS),
  localparam int BAW   = $clog2(BUF_BYTES),
  localparam int WAW   = BAW - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReq,
  input  logic                   busWe,
  input  logic                   busWord,
  input  logic                   isRom,
  input  logic [ROM_BANK_W-1:0]  romBank,
  input  logic [RAM_BANK_W-1:0]  ramBank,
  input  logic [OFF_W-1:0]       offset,
  input  logic [15:0]            busWData,
  input  logic                   selfFlash,
  output logic                   rdValid,
  output logic [15:0]            rdData,
  input  logic                   swapReq,
  input  logic                   spiActive,
  input  logic                   spiRxWe,
  input  logic [WAW-1:0]         spiRxAddr,
  input  logic [15:0]            spiRxData,
  input  logic [BAW-1:0]         spiTxAddr,
  output logic [7:0]             spiTxData,
  output logic                   psramReq,
  output logic                   psramWe,
  output logic                   psramSel,
  output logic                   psramWord,
  output logic [PS_BW+OFF_W-1:0] psramAddr,
  output logic [15:0]            psramWData,
  input  logic [15:0]            psramRData,
  output logic                   sramReq,
  output logic                   sramWe,
  output logic [SR_BW+OFF_W-1:0] sramAddr,
  output logic [7:0]             sramWData,
  input  logic [7:0]             sramRData,
  output logic                   bootReq,
  output logic [OFF_W-2:0]       bootAddr,
  input  logic [15:0]            bootRData
);

  strobe_t stb;
  logic    bufSel;

  assign bufSel = stb.bufSel;

  cbd_ctrl #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .PSRAM_BANKS(PSRAM_BANKS),
    .HAS_PSRAM1 (HAS_PSRAM1),
    .SRAM_BANKS (SRAM_BANKS),
    .BOOT_BANK  (BOOT_BANK),
    .BOOT_MIRROR(BOOT_MIRROR),
    .RX_BANK    (RX_BANK),
    .IPC_BANK   (IPC_BANK),
    .TX_BANK    (TX_BANK)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .busWe    (busWe),
    .busWord  (busWord),
    .isRom    (isRom),
    .romBank  (romBank),
    .ramBank  (ramBank),
    .selfFlash(selfFlash),
    .swapReq  (swapReq),
    .spiActive(spiActive),
    .stb      (stb)
  );

  cbd_datapath #(
    .OFF_W    (OFF_W),
    .BUF_BYTES(BUF_BYTES),
    .PS_BW    (PS_BW),
    .SR_BW    (SR_BW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .psBank    (romBank[PS_BW-1:0]),
    .srBank    (ramBank[SR_BW-1:0]),
    .offset    (offset),
    .busWData  (busWData),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .spiRxWe   (spiRxWe),
    .spiRxAddr (spiRxAddr),
    .spiRxData (spiRxData),
    .spiTxAddr (spiTxAddr),
    .spiTxData (spiTxData),
    .psramReq  (psramReq),
    .psramWe   (psramWe),
    .psramSel  (psramSel),
    .psramWord (psramWord),
    .psramAddr (psramAddr),
    .psramWData(psramWData),
    .psramRData(psramRData),
    .sramReq   (sramReq),
    .sramWe    (sramWe),
    .sramAddr  (sramAddr),
    .sramWData (sramWData),
    .sramRData (sramRData),
    .bootReq   (bootReq),
    .bootAddr  (bootAddr),
    .bootRData (bootRData)
  );

endmodule

// File: rtl/cbd_checker.sv
`timescale 1ns/1ps
module cbd_checker #(
  parameter int ROM_BANK_W  = 9,
  parameter int RAM_BANK_W  = 4,
  parameter int OFF_W       = 16,
  parameter int PSRAM_BANKS = 128,
  parameter bit HAS_PSRAM1  = 1'b1,
  parameter int SRAM_BANKS  = 8,
  parameter int BOOT_BANK   = 511,
  parameter int BOOT_MIRROR = 500,
  parameter int RX_BANK     = 510,
  localparam int PS_BW = $clog2(PSRAM_BANKS),
  localparam int SR_BW = $clog2(SRAM_BANKS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busReq,
  input logic                   busWe,
  input logic                   isRom,
  input logic [ROM_BANK_W-1:0]  romBank,
  input logic [RAM_BANK_W-1:0]  ramBank,
  input logic [OFF_W-1:0]       offset,
  input logic                   selfFlash,
  input logic                   spiActive,
  input logic                   psramReq,
  input logic                   psramWe,
  input logic                   psramSel,
  input logic                   psramWord,
  input logic [PS_BW+OFF_W-1:0] psramAddr,
  input logic                   sramReq,
  input logic                   sramWe,
  input logic                   bootReq,
  input logic [OFF_W-2:0]       bootAddr,
  input logic                   rdValid,
  input logic                   bufSel
);

  localparam logic [ROM_BANK_W-1:0] PS0_END = ROM_BANK_W'(PSRAM_BANKS);
  localparam logic [ROM_BANK_W-1:0] MAP_END = ROM_BANK_W'(HAS_PSRAM1 ? 2 * PSRAM_BANKS : PSRAM_BANKS);
  localparam logic [ROM_BANK_W-1:0] BOOT_B  = ROM_BANK_W'(BOOT_BANK);
  localparam logic [ROM_BANK_W-1:0] MIRR_B  = ROM_BANK_W'(BOOT_MIRROR);
  localparam logic [ROM_BANK_W-1:0] RX_B    = ROM_BANK_W'(RX_BANK);

  logic romOpen;
  assign romOpen = (romBank >= MAP_END) && (romBank != BOOT_B) &&
                   (romBank != MIRR_B) && (romBank != RX_B);

  AST_PSRAM_LOW_MAP: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWe && isRom && (romBank < PS0_END) |->
      psramReq && !psramSel && (psramAddr == {romBank[PS_BW-1:0], offset})); // R1

  AST_OPEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busReq && isRom && romOpen |-> !psramReq && !sramReq && !bootReq); // R2

  AST_BOOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWe && isRom && ((romBank == BOOT_B) || (romBank == MIRR_B)) |->
      bootReq && (bootAddr == offset[OFF_W-1:1])); // R3

  AST_ROM_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWe && isRom |-> !psramWe && !sramWe); // R8

  AST_SELF_FLASH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWe && !isRom && selfFlash && (romBank < PS0_END) |->
      psramWe && !psramWord && !sramReq); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWe |=> rdValid); // R12

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && !busWe) |=> !rdValid); // R12

  AST_SWAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(spiActive) |-> $stable(bufSel)); // R11

endmodule

bind cart_bank_decoder cbd_checker #(
  .ROM_BANK_W (ROM_BANK_W),
  .RAM_BANK_W (RAM_BANK_W),
  .OFF_W      (OFF_W),
  .PSRAM_BANKS(PSRAM_BANKS),
  .HAS_PSRAM1 (HAS_PSRAM1),
  .SRAM_BANKS (SRAM_BANKS),
  .BOOT_BANK  (BOOT_BANK),
  .BOOT_MIRROR(BOOT_MIRROR),
  .RX_BANK    (RX_BANK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busWe    (busWe),
  .isRom    (isRom),
  .romBank  (romBank),
  .ramBank  (ramBank),
  .offset   (offset),
  .selfFlash(selfFlash),
  .spiActive(spiActive),
  .psramReq (psramReq),
  .psramWe  (psramWe),
  .psramSel (psramSel),
  .psramWord(psramWord),
  .psramAddr(psramAddr),
  .sramReq  (sramReq),
  .sramWe   (sramWe),
  .bootReq  (bootReq),
  .bootAddr (bootAddr),
  .rdValid  (rdValid),
  .bufSel   (bufSel)
);

// File: tb/cart_bank_decoder_tb.sv
`timescale 1ns/1ps
module cart_bank_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWe = 1'b0, busWord = 1'b0, isRom = 1'b0;
  logic [8:0]  romBank = '0;
  logic [3:0]  ramBank = '0;
  logic [15:0] offset = '0;
  logic [15:0] busWData = '0;
  logic        selfFlash = 1'b0;
  logic        rdValid;
  logic [15:0] rdData;
  logic        swapReq = 1'b0, spiActive = 1'b0, spiRxWe = 1'b0;
  logic [7:0]  spiRxAddr = '0;
  logic [15:0] spiRxData = '0;
  logic [8:0]  spiTxAddr = '0;
  logic [7:0]  spiTxData;
  logic        psramReq, psramWe, psramSel, psramWord;
  logic [22:0] psramAddr;
  logic [15:0] psramWData, psramRData;
  logic        sramReq, sramWe;
  logic [18:0] sramAddr;
  logic [7:0]  sramWData, sramRData;
  logic        bootReq;
  logic [14:0] bootAddr;
  logic [15:0] bootRData;

  always #10 clk = ~clk;  // 50 MHz

  // memory stubs answering in the same cycle
  assign psramRData = psramAddr[15:0] ^ 16'hA5C3 ^ (psramSel ? 16'h0F0F : 16'h0000);
  assign sramRData  = sramAddr[7:0] ^ 8'h3C;
  assign bootRData  = {1'b1, bootAddr};

  cart_bank_decoder u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busWord(busWord),
    .isRom(isRom), .romBank(romBank), .ramBank(ramBank), .offset(offset),
    .busWData(busWData), .selfFlash(selfFlash), .rdValid(rdValid), .rdData(rdData),
    .swapReq(swapReq), .spiActive(spiActive), .spiRxWe(spiRxWe), .spiRxAddr(spiRxAddr),
    .spiRxData(spiRxData), .spiTxAddr(spiTxAddr), .spiTxData(spiTxData),
    .psramReq(psramReq), .psramWe(psramWe), .psramSel(psramSel), .psramWord(psramWord),
    .psramAddr(psramAddr), .psramWData(psramWData), .psramRData(psramRData),
    .sramReq(sramReq), .sramWe(sramWe), .sramAddr(sramAddr), .sramWData(sramWData),
    .sramRData(sramRData), .bootReq(bootReq), .bootAddr(bootAddr), .bootRData(bootRData)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  endtask

  // driver: present one access, leave it up across one rising edge
  task automatic begin_acc(input bit rom, input logic [8:0] rb, input logic [3:0] qb,
                           input logic [15:0] off, input bit we, input bit word,
                           input logic [15:0] wd, input bit sf);
    @(negedge clk);
    busReq = 1'b1; isRom = rom; romBank = rb; ramBank = qb; offset = off;
    busWe = we; busWord = word; busWData = wd; selfFlash = sf;
    #1;
  endtask

  task automatic end_acc();
    @(posedge clk);
    #1;
    busReq = 1'b0; busWe = 1'b0; selfFlash = 1'b0;
  endtask

  task automatic expect_rd(input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic rd(input bit rom, input logic [8:0] rb, input logic [3:0] qb,
                    input logic [15:0] off, input bit word, input bit sf,
                    input logic [15:0] exp, input string tag);
    begin_acc(rom, rb, qb, off, 1'b0, word, 16'h0000, sf);
    expect_rd(exp, tag);
    end_acc();
  endtask

  task automatic wr(input bit rom, input logic [8:0] rb, input logic [3:0] qb,
                    input logic [15:0] off, input logic [15:0] wd, input bit sf);
    begin_acc(rom, rb, qb, off, 1'b1, 1'b0, wd, sf);
    end_acc();
  endtask

  // monitor: compare each read result against the queue
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12 stray rdValid", {16'h0, rdData}, 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, {16'h0, rdData}, {16'h0, e});
      end
    end
  end

  task automatic pulse_swap();
    @(negedge clk); swapReq = 1'b1;
    @(posedge clk); #1; swapReq = 1'b0;
  endtask

  task automatic spi_rx_put(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); spiRxWe = 1'b1; spiRxAddr = a; spiRxData = d;
    @(posedge clk); #1; spiRxWe = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(rdValid === 1'b0, "R12 reset rdValid", {31'h0, rdValid}, 32'h0);
    check(psramReq === 1'b0, "R12 reset idle psramReq", {31'h0, psramReq}, 32'h0);

    // R1: chip 0 and chip 1 word reads
    begin_acc(1'b1, 9'd5, 4'd0, 16'h1234, 1'b0, 1'b1, 16'h0, 1'b0);
    check(psramReq && !psramSel && psramWord, "R1 chip0 strobes", {29'h0, psramReq, psramSel, psramWord}, 32'h5);
    check(psramAddr === {7'd5, 16'h1234}, "R1 chip0 addr", {9'h0, psramAddr}, {9'h0, 7'd5, 16'h1234});
    expect_rd(16'h1234 ^ 16'hA5C3, "R1 chip0 data");
    end_acc();
    begin_acc(1'b1, 9'd200, 4'd0, 16'h0100, 1'b0, 1'b1, 16'h0, 1'b0);
    check(psramReq && psramSel, "R1 chip1 select", {30'h0, psramReq, psramSel}, 32'h3);
    check(psramAddr === {7'd72, 16'h0100}, "R1 chip1 addr", {9'h0, psramAddr}, {9'h0, 7'd72, 16'h0100});
    expect_rd(16'h0100 ^ 16'hA5C3 ^ 16'h0F0F, "R1 chip1 data");
    end_acc();

    // R2: open bus in ROM gap, beside the mirror, and RAM gap
    begin_acc(1'b1, 9'd300, 4'd0, 16'h0010, 1'b0, 1'b1, 16'h0, 1'b0);
    check(!psramReq && !sramReq && !bootReq, "R2 bank300 quiet", {29'h0, psramReq, sramReq, bootReq}, 32'h0);
    expect_rd(16'hFFFF, "R2 bank300 word");
    end_acc();
    rd(1'b1, 9'd505, 4'd0, 16'h0020, 1'b1, 1'b0, 16'hFFFF, "R2 bank505 word");
    rd(1'b0, 9'd0, 4'd10, 16'h0030, 1'b0, 1'b0, 16'h00FF, "R2 ram bank10 byte");

    // R3: boot ROM and its mirror
    begin_acc(1'b1, 9'd511, 4'd0, 16'h0ABC, 1'b0, 1'b1, 16'h0, 1'b0);
    check(bootReq && bootAddr === 15'h055E, "R3 bank511 addr", {16'h0, bootReq, bootAddr}, {16'h0, 1'b1, 15'h055E});
    expect_rd(16'h855E, "R3 bank511 data");
    end_acc();
    begin_acc(1'b1, 9'd500, 4'd0, 16'h0ABC, 1'b0, 1'b1, 16'h0, 1'b0);
    check(bootReq && bootAddr === 15'h055E, "R3 bank500 addr", {16'h0, bootReq, bootAddr}, {16'h0, 1'b1, 15'h055E});
    expect_rd(16'h855E, "R3 bank500 data");
    end_acc();
    rd(1'b0, 9'd511, 4'd0, 16'h0ABD, 1'b0, 1'b1, 16'h855E, "R3 byte access full word");

    // R5: SRAM byte write, then read with busWord high
    begin_acc(1'b0, 9'd0, 4'd3, 16'h0100, 1'b1, 1'b0, 16'h775A, 1'b0);
    check(sramReq && sramWe && sramWData === 8'h5A, "R5 sram write", {23'h0, sramReq, sramWe, sramWData}, {23'h0, 2'b11, 8'h5A});
    check(sramAddr === {3'd3, 16'h0100}, "R5 sram addr", {13'h0, sramAddr}, {13'h0, 3'd3, 16'h0100});
    end_acc();
    rd(1'b0, 9'd0, 4'd3, 16'h0100, 1'b1, 1'b0, 16'h003C, "R5 sram byte read");

    // R6: scratch buffer with mirrors
    wr(1'b0, 9'd0, 4'd14, 16'h0005, 16'h0077, 1'b0);
    rd(1'b0, 9'd0, 4'd14, 16'h0205, 1'b0, 1'b0, 16'h0077, "R6 mirror 0x205");
    rd(1'b0, 9'd0, 4'd14, 16'hFE05, 1'b0, 1'b0, 16'h0077, "R6 mirror 0xFE05");

    // R7: transmit bank write, read gives open bus
    wr(1'b0, 9'd0, 4'd15, 16'h0010, 16'h0099, 1'b0);
    rd(1'b0, 9'd0, 4'd15, 16'h0010, 1'b0, 1'b0, 16'h00FF, "R7 tx read open");

    // R10: SPI fills hidden receive half, swap, console sees it
    spi_rx_put(8'h10, 16'hBEEF);
    pulse_swap();
    rd(1'b1, 9'd510, 4'd0, 16'h0020, 1'b1, 1'b0, 16'hBEEF, "R10 rx after swap");
    rd(1'b1, 9'd510, 4'd0, 16'h4220, 1'b1, 1'b0, 16'hBEEF, "R4 rx mirror");
    @(negedge clk); spiTxAddr = 9'h010;
    @(negedge clk);
    check(spiTxData === 8'h99, "R10 tx half to spi", {24'h0, spiTxData}, 32'h99);

    // R4: console write to receive bank ignored
    wr(1'b1, 9'd510, 4'd0, 16'h0020, 16'h1111, 1'b0);
    rd(1'b1, 9'd510, 4'd0, 16'h0020, 1'b1, 1'b0, 16'hBEEF, "R4 rx write ignored");

    // R8: ROM-window write to PSRAM dropped
    begin_acc(1'b1, 9'd5, 4'd0, 16'h0040, 1'b1, 1'b1, 16'hABCD, 1'b0);
    check(!psramReq && !psramWe && !sramWe, "R8 rom write dropped", {29'h0, psramReq, psramWe, sramWe}, 32'h0);
    end_acc();

    // R9: self-flash write and byte read
    begin_acc(1'b0, 9'd7, 4'd3, 16'h0042, 1'b1, 1'b1, 16'h003C, 1'b1);
    check(psramReq && psramWe && !psramWord && !sramReq, "R9 flash write strobes",
          {28'h0, psramReq, psramWe, psramWord, sramReq}, 32'hC);
    check(psramAddr === {7'd7, 16'h0042} && psramWData[7:0] === 8'h3C, "R9 flash write addr",
          {9'h0, psramAddr}, {9'h0, 7'd7, 16'h0042});
    end_acc();
    rd(1'b0, 9'd7, 4'd3, 16'h0042, 1'b1, 1'b1, {8'h00, 8'h42 ^ 8'hC3}, "R9 flash byte read");

    // R11: swap held while SPI busy
    spi_rx_put(8'h30, 16'hCAFE);
    @(negedge clk); spiActive = 1'b1;
    pulse_swap();
    rd(1'b1, 9'd510, 4'd0, 16'h0020, 1'b1, 1'b0, 16'hBEEF, "R11 swap held");
    @(negedge clk); spiActive = 1'b0;
    @(posedge clk); #1;
    rd(1'b1, 9'd510, 4'd0, 16'h0060, 1'b1, 1'b0, 16'hCAFE, "R11 swap applied");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R12 all reads returned", expQ.size(), 32'h0);
    finished = 1'b1;
    summary();
  end

endmodule